// File: doc/BRIEF.md
# Digital PLL Operating Mode Controller

This block sequences a digital PLL through its four operating modes: free-run, lock acquisition, locked and holdover. Its inputs are three loss-of-signal monitor flags for the selected reference, a history-valid flag, the loop's frequency and phase error magnitudes with their thresholds, an evaluation tick, and a pair of tuning pins used in DCO mode. From these it reports the current mode. It also drives a wide-bandwidth select for fast lock and a source select for the tuning word: loop output, history average, or the user free-run register. The loop filter, phase detector and signal monitors sit outside the block.

The mode states are FREERUN, ACQUIRE, LOCKED and HOLDOVER. There are six transitions:
- FREERUN to ACQUIRE when the reference is present.
- HOLDOVER to ACQUIRE when the reference returns.
- ACQUIRE to LOCKED after the lock qualification count has been met.
- ACQUIRE or LOCKED to HOLDOVER on loss of signal when the history is valid.
- ACQUIRE or LOCKED to FREERUN on loss of signal when there is no valid history.
- Every other case holds the current state.

A lock status bit follows the error comparisons. A sticky interrupt bit records every change of that status.

In locked or holdover mode with DCO enabled, each rising edge on the increment or decrement pin produces exactly one step request of programmable size.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset the mode output is FREERUN (code 0), the tuning select is free-run register (code 2), and fast_bw, lock_stat, lock_irq, step_up, step_dn and step_amt are all 0.
- R2: In FREERUN or HOLDOVER with loss of signal clear, the next cycle's mode is ACQUIRE (code 1), fast_bw is 1 and the tuning select is loop (code 0).
- R3: Loss of signal is the OR of los_freq, los_pulse and los_amp. Any single one of them held high keeps the block in FREERUN.
- R4: On each eval_tick, ACQUIRE counts a tick as good when freq_err <= freq_thr, phase_err <= phase_thr and loss of signal is clear. A tick that is not good restarts the count. The cycle after the tick that completes lock_count consecutive good ticks (lock_count >= 1), the mode becomes LOCKED (code 2) and fast_bw returns to 0, with the tuning select at loop.
- R5: Loss of signal in ACQUIRE or LOCKED moves the block on the next cycle to HOLDOVER (code 3, tuning select history code 1) if hist_valid is 1, and otherwise to FREERUN (tuning select code 2).
- R6: In LOCKED or HOLDOVER with dco_en = 1, a rising edge on inc_pin or dec_pin gives exactly one single-cycle pulse on step_up or step_dn, with step_amt equal to step_size, whatever the pin's high time.
- R7: Pin edges produce no step in FREERUN or ACQUIRE, or when dco_en is 0.
- R8: Rising edges on both pins in the same cycle cancel and produce no step.
- R9: On each eval_tick, lock_stat is loaded with 1 if both error comparisons of R4 hold and loss of signal is clear, and with 0 otherwise. Between ticks it holds its value.
- R10: lock_irq is set one cycle after any change of lock_stat and stays set until irq_clr is high. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| los_freq | input | 1 | Frequency monitor loss flag |
| los_pulse | input | 1 | Missing-pulse monitor loss flag |
| los_amp | input | 1 | Amplitude monitor loss flag |
| hist_valid | input | 1 | Tuning history average is usable |
| eval_tick | input | 1 | Lock evaluation strobe |
| freq_err | input | ERR_W | Frequency error magnitude |
| freq_thr | input | ERR_W | Frequency lock threshold |
| phase_err | input | ERR_W | Phase error magnitude |
| phase_thr | input | ERR_W | Phase lock threshold |
| lock_count | input | CNT_W | Consecutive good ticks needed for lock |
| dco_en | input | 1 | DCO pin stepping enable |
| inc_pin | input | 1 | Asynchronous increment pin |
| dec_pin | input | 1 | Asynchronous decrement pin |
| step_size | input | STEP_W | Tuning step size |
| irq_clr | input | 1 | Write-one-to-clear for lock_irq |
| mode | output | 2 | Current mode: 0 free-run, 1 acquire, 2 locked, 3 holdover |
| fast_bw | output | 1 | Wide loop bandwidth select |
| tw_sel | output | 2 | Tuning source: 0 loop, 1 history, 2 free-run register |
| step_up | output | 1 | Increment step request pulse |
| step_dn | output | 1 | Decrement step request pulse |
| step_amt | output | STEP_W | Step size accompanying a pulse, else 0 |
| lock_stat | output | 1 | Lock status |
| lock_irq | output | 1 | Sticky lock-status-change interrupt |

## Verification
Mode, fast_bw and tw_sel change one cycle after a loss-of-signal change or after the qualifying tick. The bench drives on the falling edge and checks on the next falling edge, and it confirms that the mode is still ACQUIRE right after the last qualifying tick. lock_stat changes with the tick's own edge and lock_irq one cycle later, so each is checked in its own cycle. A step pulse appears three cycles after the pin edge, passing through two synchroniser stages and the pulse register. A falling-edge monitor therefore counts pulses over a window of several cycles after each pin stimulus, and the bench checks exact counts of one or zero.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
    typedef enum logic [1:0] {
        MODE_FREERUN  = 2'd0,
        MODE_ACQUIRE  = 2'd1,
        MODE_LOCKED   = 2'd2,
        MODE_HOLDOVER = 2'd3
    } dpll_mode_e;

    typedef enum logic [1:0] {
        TW_LOOP    = 2'd0,
        TW_HISTORY = 2'd1,
        TW_FREERUN = 2'd2
    } tw_src_e;
endpackage

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
    parameter int ERR_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             eval_tick,
    input  logic             los,
    input  logic [ERR_W-1:0] freq_err,
    input  logic [ERR_W-1:0] freq_thr,
    input  logic [ERR_W-1:0] phase_err,
    input  logic [ERR_W-1:0] phase_thr,
    input  logic [CNT_W-1:0] lock_count,
    output logic             qualified,
    output logic             lock_stat
);
    logic             good;
    logic [CNT_W-1:0] good_cnt;

    assign good = (freq_err <= freq_thr) && (phase_err <= phase_thr) && !los;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_cnt <= '0;
        end else if (!run) begin
            good_cnt <= '0;
        end else if (eval_tick) begin
            if (!good)
                good_cnt <= '0;
            else if (good_cnt < lock_count)
                good_cnt <= good_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_stat <= 1'b0;
        else if (eval_tick)
            lock_stat <= good;
    end

    assign qualified = run && (good_cnt >= lock_count);

    // R4: a failing tick leaves the counter unable to qualify on the next cycle
    a_r4_bad_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (run && eval_tick && !good && lock_count != '0) |=> (good_cnt == '0));
    // R9: status is frozen between ticks
    a_r9_stat_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_tick |=> $stable(lock_stat));
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import dpll_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       los,
    input  logic       hist_valid,
    input  logic       qualified,
    output dpll_mode_e state_q,
    output logic       fast_bw,
    output tw_src_e    tw_sel,
    output logic       step_allow_in,
    input  logic       dco_en
);
    dpll_mode_e state_d;
    dpll_mode_e fallback;

    assign fallback = hist_valid ? MODE_HOLDOVER : MODE_FREERUN;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_FREERUN:  if (!los) state_d = MODE_ACQUIRE;
            MODE_HOLDOVER: if (!los) state_d = MODE_ACQUIRE;
            MODE_ACQUIRE: begin
                if (los)            state_d = fallback;
                else if (qualified) state_d = MODE_LOCKED;
            end
            MODE_LOCKED:   if (los) state_d = fallback;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_FREERUN;
        else        state_q <= state_d;
    end

    always_comb begin
        fast_bw       = 1'b0;
        tw_sel        = TW_LOOP;
        step_allow_in = 1'b0;
        unique case (state_q)
            MODE_FREERUN:  tw_sel = TW_FREERUN;
            MODE_ACQUIRE:  fast_bw = 1'b1;
            MODE_LOCKED:   step_allow_in = dco_en;
            MODE_HOLDOVER: begin
                tw_sel        = TW_HISTORY;
                step_allow_in = dco_en;
            end
        endcase
    end

    // R2: a present reference pulls free-run and holdover into acquisition
    a_r2_enter_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_FREERUN || state_q == MODE_HOLDOVER) && !los)
        |=> (state_q == MODE_ACQUIRE));
    // R5: loss with history goes to holdover
    a_r5_to_holdover: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_ACQUIRE || state_q == MODE_LOCKED) && los && hist_valid)
        |=> (state_q == MODE_HOLDOVER));
    // R5: loss without history goes to free-run
    a_r5_to_freerun: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_ACQUIRE || state_q == MODE_LOCKED) && los && !hist_valid)
        |=> (state_q == MODE_FREERUN));
    // R4: no lock without qualification
    a_r4_lock_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_ACQUIRE && !los && !qualified) |=> (state_q == MODE_ACQUIRE));
    // R3: loss of signal holds free-run
    a_r3_freerun_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_FREERUN && los) |=> (state_q == MODE_FREERUN));
endmodule

// File: rtl/pin_stepper.sv
module pin_stepper #(
    parameter int STEP_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_pin,
    input  logic              dec_pin,
    input  logic              allow,
    input  logic [STEP_W-1:0] step_size,
    output logic              step_up,
    output logic              step_dn,
    output logic [STEP_W-1:0] step_amt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [1:0] sync_q [SYNC_STAGES];
    logic [1:0] prev_q;
    logic [1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 2'b00;
            prev_q <= 2'b00;
        end else begin
            sync_q[0] <= {dec_pin, inc_pin};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_up  <= 1'b0;
            step_dn  <= 1'b0;
            step_amt <= '0;
        end else begin
            step_up  <= allow && rise[0] && !rise[1];
            step_dn  <= allow && rise[1] && !rise[0];
            step_amt <= (allow && (rise[0] ^ rise[1])) ? step_size : '0;
        end
    end

    // R8: never both directions at once
    a_r8_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));
    // R7: a step only follows a cycle where stepping was allowed
    a_r7_step_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> $past(allow));
    // R6: a pulse lasts a single cycle
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> !step_up);
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
#(
    parameter int ERR_W  = 16,
    parameter int CNT_W  = 8,
    parameter int STEP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_freq,
    input  logic              los_pulse,
    input  logic              los_amp,
    input  logic              hist_valid,
    input  logic              eval_tick,
    input  logic [ERR_W-1:0]  freq_err,
    input  logic [ERR_W-1:0]  freq_thr,
    input  logic [ERR_W-1:0]  phase_err,
    input  logic [ERR_W-1:0]  phase_thr,
    input  logic [CNT_W-1:0]  lock_count,
    input  logic              dco_en,
    input  logic              inc_pin,
    input  logic              dec_pin,
    input  logic [STEP_W-1:0] step_size,
    input  logic              irq_clr,
    output logic [1:0]        mode,
    output logic              fast_bw,
    output logic [1:0]        tw_sel,
    output logic              step_up,
    output logic              step_dn,
    output logic [STEP_W-1:0] step_amt,
    output logic              lock_stat,
    output logic              lock_irq
);
    logic       los;
    dpll_mode_e state;
    tw_src_e    tw_src;
    logic       qualified;
    logic       allow;
    logic       stat_q;
    logic       stat_chg;

    assign los = los_freq | los_pulse | los_amp;

    mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .los           (los),
        .hist_valid    (hist_valid),
        .qualified     (qualified),
        .state_q       (state),
        .fast_bw       (fast_bw),
        .tw_sel        (tw_src),
        .step_allow_in (allow),
        .dco_en        (dco_en)
    );

    lock_qualifier #(.ERR_W(ERR_W), .CNT_W(CNT_W)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state == MODE_ACQUIRE),
        .eval_tick  (eval_tick),
        .los        (los),
        .freq_err   (freq_err),
        .freq_thr   (freq_thr),
        .phase_err  (phase_err),
        .phase_thr  (phase_thr),
        .lock_count (lock_count),
        .qualified  (qualified),
        .lock_stat  (lock_stat)
    );

    pin_stepper #(.STEP_W(STEP_W), .SYNC_STAGES(2)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_pin   (inc_pin),
        .dec_pin   (dec_pin),
        .allow     (allow),
        .step_size (step_size),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .step_amt  (step_amt)
    );

    assign mode   = state;
    assign tw_sel = tw_src;

    assign stat_chg = lock_stat ^ stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q   <= 1'b0;
            lock_irq <= 1'b0;
        end else begin
            stat_q <= lock_stat;
            if (stat_chg)     lock_irq <= 1'b1;
            else if (irq_clr) lock_irq <= 1'b0;
        end
    end

    // R10: interrupt stays set until cleared
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_irq && !irq_clr) |=> lock_irq);
    // R10: a status change always raises the interrupt
    a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_stat != $past(lock_stat)) |=> lock_irq);
endmodule

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;
    localparam int ERR_W  = 16;
    localparam int CNT_W  = 8;
    localparam int STEP_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              los_freq = 1'b1, los_pulse = 1'b0, los_amp = 1'b0;
    logic              hist_valid = 1'b0, eval_tick = 1'b0;
    logic [ERR_W-1:0]  freq_err = '0, freq_thr = 16'd100;
    logic [ERR_W-1:0]  phase_err = '0, phase_thr = 16'd50;
    logic [CNT_W-1:0]  lock_count = 8'd3;
    logic              dco_en = 1'b0, inc_pin = 1'b0, dec_pin = 1'b0;
    logic [STEP_W-1:0] step_size = 12'h2A5;
    logic              irq_clr = 1'b0;
    logic [1:0]        mode, tw_sel;
    logic              fast_bw, step_up, step_dn, lock_stat, lock_irq;
    logic [STEP_W-1:0] step_amt;

    int errors = 0;
    int checks = 0;
    int up_cnt = 0, dn_cnt = 0, bad_amt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dpll_mode_ctrl #(.ERR_W(ERR_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .los_freq(los_freq), .los_pulse(los_pulse),
        .los_amp(los_amp), .hist_valid(hist_valid), .eval_tick(eval_tick),
        .freq_err(freq_err), .freq_thr(freq_thr), .phase_err(phase_err),
        .phase_thr(phase_thr), .lock_count(lock_count), .dco_en(dco_en),
        .inc_pin(inc_pin), .dec_pin(dec_pin), .step_size(step_size),
        .irq_clr(irq_clr), .mode(mode), .fast_bw(fast_bw), .tw_sel(tw_sel),
        .step_up(step_up), .step_dn(step_dn), .step_amt(step_amt),
        .lock_stat(lock_stat), .lock_irq(lock_irq)
    );

    always @(negedge clk) begin
        if (step_up) up_cnt++;
        if (step_dn) dn_cnt++;
        if ((step_up || step_dn) && step_amt != step_size) bad_amt++;
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic tick();
        eval_tick = 1'b1;
        @(negedge clk);
        eval_tick = 1'b0;
    endtask

    task automatic pins(input logic up, input logic dn, input int hold);
        up_cnt = 0; dn_cnt = 0; bad_amt = 0;
        inc_pin = up; dec_pin = dn;
        repeat (hold) @(negedge clk);
        inc_pin = 1'b0; dec_pin = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode", mode, 0);
        check("R1 tw_sel", tw_sel, 2);
        check("R1 fast_bw", fast_bw, 0);
        check("R1 lock_stat/irq", {lock_stat, lock_irq}, 0);
        check("R1 steps", {step_up, step_dn, step_amt}, 0);
    endtask

    task automatic t_los_or();
        los_freq = 1'b1; los_pulse = 1'b0; los_amp = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 freq flag holds free-run", mode, 0);
        los_freq = 1'b0; los_pulse = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 pulse flag holds free-run", mode, 0);
        los_pulse = 1'b0; los_amp = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 amp flag holds free-run", mode, 0);
        los_amp = 1'b0;
        @(negedge clk);
        check("R2 mode acquire", mode, 1);
        check("R2 fast_bw", fast_bw, 1);
        check("R2 tw_sel loop", tw_sel, 0);
    endtask

    task automatic t_lock();
        tick();
        check("R9 lock_stat after good tick", lock_stat, 1);
        @(negedge clk);
        check("R10 irq on rise", lock_irq, 1);
        freq_err = 16'd101;
        tick();
        freq_err = 16'd100;
        check("R9 lock_stat after bad tick", lock_stat, 0);
        check("R4 still acquiring", mode, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R10 set wins over clear", lock_irq, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R10 irq cleared", lock_irq, 0);
        repeat (3) @(negedge clk);
        check("R10 irq stays clear", lock_irq, 0);
        phase_err = 16'd50;
        tick();
        tick();
        check("R4 two ticks not enough", mode, 1);
        tick();
        check("R4 mode acquire right after last tick", mode, 1);
        @(negedge clk);
        check("R4 mode locked", mode, 2);
        check("R4 fast_bw nominal", fast_bw, 0);
        check("R4 tw_sel loop", tw_sel, 0);
        check("R10 irq on second rise", lock_irq, 1);
    endtask

    task automatic t_dco_locked();
        dco_en = 1'b0;
        pins(1'b1, 1'b0, 3);
        check("R7 dco disabled no step", up_cnt + dn_cnt, 0);
        dco_en = 1'b1;
        pins(1'b1, 1'b0, 2);
        check("R6 one up step", up_cnt, 1);
        check("R6 no down step", dn_cnt, 0);
        check("R6 step_amt", bad_amt, 0);
        pins(1'b0, 1'b1, 8);
        check("R6 long dec pulse one step", dn_cnt, 1);
        check("R6 no up on dec", up_cnt, 0);
        pins(1'b1, 1'b1, 3);
        check("R8 both edges cancel", up_cnt + dn_cnt, 0);
    endtask

    task automatic t_holdover();
        hist_valid = 1'b1;
        los_amp = 1'b1;
        @(negedge clk);
        check("R5 holdover mode", mode, 3);
        check("R5 holdover tw_sel history", tw_sel, 1);
        tick();
        check("R9 lock_stat cleared by loss", lock_stat, 0);
        pins(1'b1, 1'b0, 3);
        check("R6 step in holdover", up_cnt, 1);
        los_amp = 1'b0;
        @(negedge clk);
        check("R2 holdover to acquire", mode, 1);
        pins(1'b1, 1'b0, 3);
        check("R7 no step in acquire", up_cnt + dn_cnt, 0);
        hist_valid = 1'b0;
        los_freq = 1'b1;
        @(negedge clk);
        check("R5 no history to free-run", mode, 0);
        check("R5 free-run tw_sel", tw_sel, 2);
        pins(1'b0, 1'b1, 3);
        check("R7 no step in free-run", up_cnt + dn_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_los_or();
        t_lock();
        t_dco_locked();
        t_holdover();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule